// File: doc/BRIEF.md
# Host Slave Interface Buffer

This block sits between an 8-bit master bus and a small peripheral controller. The host sees two byte-wide locations, selected by `hostA0`. Writes go to an input data register. A write with `hostA0` high is a command and a write with `hostA0` low is data; the command/data choice is remembered in a status flag. Reads return either a status byte or the contents of an output data register. All host strobes are sampled in the block clock domain, and register updates happen only when a strobe is released.

The local controller is modelled by a few single-cycle strobes and data ports. It can load the output register, consume the input register, write the user half of the status byte and write a three-bit pin latch. It can also switch on two optional pin modes. In flag mode, two pins show buffer-full conditions so the host can take interrupts. In DMA mode, one pin carries a transfer request, and an acknowledge input selects the data registers as a chip select would. Until a mode is enabled, its pins simply reflect the pin latch.

Top module: `hostIfBuffer`

## Requirements
- R1: After reset the status byte reads 0x00, the input and output buffer-full flags are clear, all three pin latch bits are 1 so `obfPin`, `ibfPin` and `drqPin` are all 1, and `hostDataOe` is 0.
- R2: Status bit order from bit 7 to bit 0 is USR3, USR2, USR1, USR0, CMD, F0, IBF, OBF, and F0 reads 0. A local status write copies only bits 7..4 of `locStsData` into USR3..USR0.
- R3: A completed host write loads `hostDataIn` into the input register (seen on `locInData`) and sets IBF. It sets CMD when `hostA0` was 1 and clears CMD when `hostA0` was 0.
- R4: Host strobes act on their trailing edge only. While `hostWrN` or `hostRdN` is still low, IBF, OBF, CMD and the input register keep their values. The update is visible after the first clock edge at which the strobe is sampled high.
- R5: While the host reads status (select active, `hostRdN` low, `hostA0` 1), a local status write does not change the status byte being read. The write takes effect when the read ends.
- R6: A local output write loads the output register and sets OBF. A host read with `hostA0`=0 returns the output register and clears OBF when it ends. A local input read (`locInRd`) clears IBF.
- R7: Once flag mode is enabled (`locEnFlags`), `obfPin` equals OBF when pin latch bit 0 is 1 and is 0 when that bit is 0. Before flag mode, `obfPin` equals latch bit 0.
- R8: Once flag mode is enabled, `ibfPin` equals the inverse of IBF when pin latch bit 1 is 1 and is 0 when that bit is 0. Before flag mode, `ibfPin` equals latch bit 1.
- R9: Once DMA mode is enabled (`locEnDma`), a pin latch write with bit 2 set raises `drqPin`. The request drops at the end of a host read or write made under an active `hostDackN`, or when `locEnDma` is pulsed again. Before DMA mode, `drqPin` equals latch bit 2.
- R10: In DMA mode an active `hostDackN` selects the data registers without `hostCsN`. Such an access always uses the data location, as if `hostA0` were 0.
- R11: `hostDataOut` is driven (`hostDataOe`=1) only while the block is selected and `hostRdN` is low. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostCsN | input | 1 | Host chip select, active low |
| hostA0 | input | 1 | Host address: 1 selects command/status, 0 selects data |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostDackN | input | 1 | DMA acknowledge, active low; acts as data select in DMA mode |
| hostDataIn | input | 8 | Host write data |
| hostDataOut | output | 8 | Host read data |
| hostDataOe | output | 1 | High while read data is driven |
| locOutWr | input | 1 | Local strobe: load the output register |
| locOutData | input | 8 | Byte for the output register |
| locInRd | input | 1 | Local strobe: input register consumed |
| locInData | output | 8 | Current input register contents |
| locStsWr | input | 1 | Local strobe: write the user status nibble |
| locStsData | input | 8 | Status write byte; bits 7..4 used |
| locPinWr | input | 1 | Local strobe: write the pin latch |
| locPinData | input | 3 | Pin latch bits: 0 OBF gate, 1 IBF gate, 2 DRQ |
| locEnFlags | input | 1 | Local strobe: enter flag mode |
| locEnDma | input | 1 | Local strobe: enter DMA mode and clear the request |
| obfPin | output | 1 | Output-buffer-full pin or latch bit 0 |
| ibfPin | output | 1 | Inverted input-buffer-full pin or latch bit 1 |
| drqPin | output | 1 | DMA request pin or latch bit 2 |

## Verification
The bench sweeps every byte value through host writes, with the command/data select alternating, and through local output writes read back by the host. It also holds each strobe low across several clocks. A design that updated on the falling edge would show IBF or a new input byte early. One that mixed up the select would read back CMD with the wrong value. A local status write landing in the middle of a status read is checked twice, once during the read and once after it. A block without the hold would change the byte mid-read, and one that dropped the pending write would never show the new nibble. The DMA sequences check that acknowledge alone selects data and forces the data location, and that the request falls only on the three named events. The pin checks cover both gate settings before and after each mode is enabled.

// File: rtl/hostIfPkg.sv
package hostIfPkg;
  localparam int DataW = 8;
  localparam int NibW  = DataW / 2;
  localparam int PinW  = 3;

  typedef struct packed {
    logic             wrDone;     // host write released this cycle
    logic             wrA0;       // select level latched for that write
    logic [DataW-1:0] wrByte;     // byte latched for that write
    logic             rdDataDone; // host data read released this cycle
    logic             dackDone;   // access under acknowledge released
    logic             stsHold;    // host is reading status now
    logic             busOe;      // read data driven
    logic             busSts;     // read data is the status byte
  } hostStrb_t;
endpackage

// File: rtl/hostIfCtrl.sv
module hostIfCtrl
  import hostIfPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostCsN,
  input  logic             hostA0,
  input  logic             hostRdN,
  input  logic             hostWrN,
  input  logic             hostDackN,
  input  logic [DataW-1:0] hostDataIn,
  input  logic             dmaOn,
  output hostStrb_t        strb
);
  logic selNow, dackNow, a0Eff;
  logic prevRdN, prevWrN;
  logic latSel, latA0, latDack;
  logic [DataW-1:0] latByte;
  logic wrRise, rdRise;

  assign dackNow = dmaOn & ~hostDackN;
  assign selNow  = ~hostCsN | dackNow;
  assign a0Eff   = dackNow ? 1'b0 : hostA0;
  assign wrRise  = ~prevWrN & hostWrN;
  assign rdRise  = ~prevRdN & hostRdN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevRdN <= 1'b1;
      prevWrN <= 1'b1;
      latSel  <= 1'b0;
      latA0   <= 1'b0;
      latDack <= 1'b0;
      latByte <= '0;
    end else begin
      prevRdN <= hostRdN;
      prevWrN <= hostWrN;
      if (!hostRdN || !hostWrN) begin
        latSel  <= selNow;
        latA0   <= a0Eff;
        latDack <= dackNow;
        latByte <= hostDataIn;
      end
    end
  end

  always_comb begin
    strb.wrDone     = wrRise & latSel;
    strb.wrA0       = latA0;
    strb.wrByte     = latByte;
    strb.rdDataDone = rdRise & latSel & ~latA0;
    strb.dackDone   = latDack & (wrRise | rdRise);
    strb.stsHold    = selNow & ~hostRdN & a0Eff;
    strb.busOe      = selNow & ~hostRdN;
    strb.busSts     = a0Eff;
  end

  // R4: a write completion is only reported after the strobe was low
  a_r4_write_after_low: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDone |-> $past(!hostWrN));
  // R11: read data is never driven while the read strobe is high
  a_r11_no_drive_idle: assert property (@(posedge clk) disable iff (!rstN)
    hostRdN |-> !strb.busOe);
endmodule

// File: rtl/hostIfData.sv
module hostIfData
  import hostIfPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  hostStrb_t        strb,
  input  logic             locOutWr,
  input  logic [DataW-1:0] locOutData,
  input  logic             locInRd,
  output logic [DataW-1:0] locInData,
  input  logic             locStsWr,
  input  logic [DataW-1:0] locStsData,
  input  logic             locPinWr,
  input  logic [PinW-1:0]  locPinData,
  input  logic             locEnFlags,
  input  logic             locEnDma,
  output logic [DataW-1:0] hostDataOut,
  output logic             hostDataOe,
  output logic             obfPin,
  output logic             ibfPin,
  output logic             drqPin,
  output logic             dmaOn
);
  logic [DataW-1:0] inReg, outReg, stsByte;
  logic [NibW-1:0]  usrNib, pendNib;
  logic             pendValid, obf, ibf, cmdFlag, flagsOn, drq;
  logic [PinW-1:0]  pinLat;

  assign stsByte = {usrNib, cmdFlag, 1'b0, ibf, obf};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReg <= '0; outReg <= '0; usrNib <= '0; pendNib <= '0;
      pendValid <= 1'b0; obf <= 1'b0; ibf <= 1'b0; cmdFlag <= 1'b0;
      flagsOn <= 1'b0; dmaOn <= 1'b0; drq <= 1'b0; pinLat <= '1;
    end else begin
      if (strb.wrDone) begin
        inReg   <= strb.wrByte;
        cmdFlag <= strb.wrA0;
      end
      if (strb.wrDone)  ibf <= 1'b1;
      else if (locInRd) ibf <= 1'b0;
      if (locOutWr) begin
        outReg <= locOutData;
        obf    <= 1'b1;
      end else if (strb.rdDataDone) begin
        obf <= 1'b0;
      end
      if (locStsWr && strb.stsHold) begin
        pendNib   <= locStsData[DataW-1:NibW];
        pendValid <= 1'b1;
      end else if (locStsWr) begin
        usrNib    <= locStsData[DataW-1:NibW];
        pendValid <= 1'b0;
      end else if (pendValid && !strb.stsHold) begin
        usrNib    <= pendNib;
        pendValid <= 1'b0;
      end
      if (locPinWr) pinLat <= locPinData;
      if (locEnFlags) flagsOn <= 1'b1;
      if (locEnDma) dmaOn <= 1'b1;
      if (locEnDma || strb.dackDone) drq <= 1'b0;
      else if (locPinWr && locPinData[2] && dmaOn) drq <= 1'b1;
    end
  end

  assign locInData   = inReg;
  assign hostDataOe  = strb.busOe;
  assign hostDataOut = strb.busOe ? (strb.busSts ? stsByte : outReg) : '0;
  assign obfPin = flagsOn ? (pinLat[0] & obf)  : pinLat[0];
  assign ibfPin = flagsOn ? (pinLat[1] & ~ibf) : pinLat[1];
  assign drqPin = dmaOn ? drq : pinLat[2];

  // R5: user nibble frozen across consecutive status-read cycles
  a_r5_sts_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stsHold && $past(strb.stsHold)) |-> $stable(usrNib));
  // R3: IBF only rises after a completed host write
  a_r3_ibf_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ibf) |-> $past(strb.wrDone));
  // R6: OBF only rises after a local output write
  a_r6_obf_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(obf) |-> $past(locOutWr));
  // R9: request only falls on acknowledge completion or mode re-entry
  a_r9_drq_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(drq) |-> $past(strb.dackDone || locEnDma));
endmodule

// File: rtl/hostIfBuffer.sv
module hostIfBuffer
  import hostIfPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostCsN,
  input  logic             hostA0,
  input  logic             hostRdN,
  input  logic             hostWrN,
  input  logic             hostDackN,
  input  logic [DataW-1:0] hostDataIn,
  output logic [DataW-1:0] hostDataOut,
  output logic             hostDataOe,
  input  logic             locOutWr,
  input  logic [DataW-1:0] locOutData,
  input  logic             locInRd,
  output logic [DataW-1:0] locInData,
  input  logic             locStsWr,
  input  logic [DataW-1:0] locStsData,
  input  logic             locPinWr,
  input  logic [PinW-1:0]  locPinData,
  input  logic             locEnFlags,
  input  logic             locEnDma,
  output logic             obfPin,
  output logic             ibfPin,
  output logic             drqPin
);
  hostStrb_t strb;
  logic      dmaOn;

  hostIfCtrl uCtrl (
    .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostA0(hostA0),
    .hostRdN(hostRdN), .hostWrN(hostWrN), .hostDackN(hostDackN),
    .hostDataIn(hostDataIn), .dmaOn(dmaOn), .strb(strb)
  );

  hostIfData uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .locOutWr(locOutWr), .locOutData(locOutData), .locInRd(locInRd),
    .locInData(locInData), .locStsWr(locStsWr), .locStsData(locStsData),
    .locPinWr(locPinWr), .locPinData(locPinData), .locEnFlags(locEnFlags),
    .locEnDma(locEnDma), .hostDataOut(hostDataOut), .hostDataOe(hostDataOe),
    .obfPin(obfPin), .ibfPin(ibfPin), .drqPin(drqPin), .dmaOn(dmaOn)
  );
endmodule

// File: tb/tb_hostIfBuffer.sv
module tb_hostIfBuffer;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostCsN = 1'b1, hostA0 = 1'b0, hostRdN = 1'b1, hostWrN = 1'b1, hostDackN = 1'b1;
  logic [7:0] hostDataIn = '0, hostDataOut, locOutData = '0, locInData, locStsData = '0;
  logic hostDataOe, locOutWr = 0, locInRd = 0, locStsWr = 0, locPinWr = 0;
  logic locEnFlags = 0, locEnDma = 0, obfPin, ibfPin, drqPin;
  logic [2:0] locPinData = '0;
  int nChecks = 0, nFails = 0;
  logic [3:0] expNib = '0;
  logic expCmd = 0, expIbf = 0, expObf = 0;
  logic [7:0] rb;

  always #(ClkPeriod/2) clk = ~clk;

  hostIfBuffer dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expSts();
    return {expNib, expCmd, 1'b0, expIbf, expObf};
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic hostWrite(input logic a0, input logic [7:0] b, input logic useDack);
    tick();
    if (useDack) hostDackN = 0; else hostCsN = 0;
    hostA0 = a0; hostDataIn = b; hostWrN = 0;
    tick(); tick();
    hostWrN = 1;
    tick();
    hostCsN = 1; hostDackN = 1;
  endtask

  task automatic hostRead(input logic a0, input logic useDack, output logic [7:0] d);
    tick();
    if (useDack) hostDackN = 0; else hostCsN = 0;
    hostA0 = a0; hostRdN = 0;
    tick();
    d = hostDataOut;
    chk("R11 oe during read", {7'b0, hostDataOe}, 8'd1);
    hostRdN = 1;
    tick();
    hostCsN = 1; hostDackN = 1;
  endtask

  task automatic pulse(ref logic s);
    tick(); s = 1; tick(); s = 0;
  endtask

  initial begin
    #(ClkPeriod * 200000);
    nFails++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    // R1 reset state
    hostRead(1'b1, 1'b0, rb);
    chk("R1 status after reset", rb, 8'h00);
    chk("R1 pins after reset", {5'b0, drqPin, ibfPin, obfPin}, 8'h07);
    chk("R1 oe idle", {7'b0, hostDataOe}, 8'h00);

    // R3/R6 sweep of host writes and local consumes
    for (int v = 0; v < 256; v++) begin
      hostWrite(v[0], v[7:0], 1'b0);
      expCmd = v[0]; expIbf = 1;
      chk("R3 input byte", locInData, v[7:0]);
      hostRead(1'b1, 1'b0, rb);
      chk("R3 status after write", rb, expSts());
      pulse(locInRd); expIbf = 0;
      tick();
      hostRead(1'b1, 1'b0, rb);
      chk("R6 IBF cleared by local read", rb, expSts());
    end
    chk("R11 bus quiet", hostDataOut, 8'h00);

    // R6 sweep of output register
    for (int v = 0; v < 256; v++) begin
      tick(); locOutData = v[7:0]; locOutWr = 1; tick(); locOutWr = 0;
      expObf = 1;
      hostRead(1'b1, 1'b0, rb);
      chk("R6 OBF set", rb, expSts());
      hostRead(1'b0, 1'b0, rb);
      chk("R6 data read", rb, v[7:0]);
      expObf = 0;
      hostRead(1'b1, 1'b0, rb);
      chk("R6 OBF cleared by host read", rb, expSts());
    end

    // R2 status nibble writes
    for (int v = 0; v < 256; v += 17) begin
      tick(); locStsData = v[7:0]; locStsWr = 1; tick(); locStsWr = 0;
      expNib = v[7:4];
      hostRead(1'b1, 1'b0, rb);
      chk("R2 nibble only", rb, expSts());
    end

    // R8 and R4: strobe held low keeps flags
    pulse(locEnFlags);
    tick(); locPinData = 3'b011; locPinWr = 1; tick(); locPinWr = 0;
    tick();
    chk("R8 ibfPin empty", {7'b0, ibfPin}, 8'd1);
    chk("R7 obfPin empty", {7'b0, obfPin}, 8'd0);
    tick(); hostCsN = 0; hostA0 = 0; hostDataIn = 8'h5A; hostWrN = 0;
    repeat (4) tick();
    chk("R4 no early IBF", {7'b0, ibfPin}, 8'd1);
    chk("R4 no early data", locInData, 8'hFF);
    hostWrN = 1; tick(); hostCsN = 1;
    expIbf = 1; expCmd = 0;
    chk("R4 data after release", locInData, 8'h5A);
    chk("R8 ibfPin full", {7'b0, ibfPin}, 8'd0);
    tick(); locPinData = 3'b001; locPinWr = 1; tick(); locPinWr = 0;
    tick();
    chk("R8 ibfPin gated low", {7'b0, ibfPin}, 8'd0);
    pulse(locInRd); expIbf = 0; tick();
    chk("R8 gated stays low when empty", {7'b0, ibfPin}, 8'd0);
    tick(); locOutData = 8'h33; locOutWr = 1; tick(); locOutWr = 0; expObf = 1;
    tick();
    chk("R7 obfPin full", {7'b0, obfPin}, 8'd1);
    tick(); locPinData = 3'b010; locPinWr = 1; tick(); locPinWr = 0; tick();
    chk("R7 obfPin gated", {7'b0, obfPin}, 8'd0);
    hostRead(1'b0, 1'b0, rb); expObf = 0;

    // R5 status hold during read
    tick(); hostCsN = 0; hostA0 = 1; hostRdN = 0;
    tick(); locStsData = 8'hC0; locStsWr = 1; tick(); locStsWr = 0;
    tick();
    chk("R5 held during read", hostDataOut, expSts());
    hostRdN = 1; tick(); hostCsN = 1;
    expNib = 4'hC;
    hostRead(1'b1, 1'b0, rb);
    chk("R5 applied after read", rb, expSts());

    // R9/R10 DMA
    chk("R9 drq pre-DMA follows latch", {7'b0, drqPin}, 8'd0);
    pulse(locEnDma); tick();
    tick(); locPinData = 3'b100; locPinWr = 1; tick(); locPinWr = 0; tick();
    chk("R9 drq raised", {7'b0, drqPin}, 8'd1);
    hostWrite(1'b1, 8'hA7, 1'b1);
    expIbf = 1; expCmd = 0;
    chk("R9 drq cleared by dack write", {7'b0, drqPin}, 8'd0);
    chk("R10 dack write data", locInData, 8'hA7);
    hostRead(1'b1, 1'b0, rb);
    chk("R10 dack forces data select", rb, expSts());
    pulse(locInRd); expIbf = 0;
    tick(); locPinData = 3'b100; locPinWr = 1; tick(); locPinWr = 0;
    tick(); locOutData = 8'h9C; locOutWr = 1; tick(); locOutWr = 0; expObf = 1;
    hostRead(1'b1, 1'b1, rb);
    chk("R10 dack read returns data", rb, 8'h9C);
    expObf = 0;
    chk("R9 drq cleared by dack read", {7'b0, drqPin}, 8'd0);
    tick(); locPinData = 3'b100; locPinWr = 1; tick(); locPinWr = 0;
    pulse(locEnDma); tick();
    chk("R9 drq cleared by enable", {7'b0, drqPin}, 8'd0);
    hostRead(1'b1, 1'b0, rb);
    chk("R6 status after DMA", rb, expSts());

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule